// File: doc/BRIEF.md
# Transmit Descriptor Ring Scanner

This block serves the transmit side of a network controller. It keeps a ring of transmit descriptors in shared memory and walks that ring through a byte-wide request/response memory port. When the controller's transmit path is running and a poll request arrives, the scanner starts at its current ring index. It fetches each descriptor's status byte. Every descriptor that the device owns and that holds a whole packet is then serviced: the scanner decodes the stored length, which is kept in negative form, and streams that many bytes from the buffer paired with that ring slot. It then returns the descriptor to software and signals completion.

Each descriptor takes 8 bytes. Offset 2 holds the status byte and offsets 4 and 5 hold the length. The data buffer for ring slot `i` sits at a fixed address, `BUF_BASE + i * 2^BUF_LOG`. Each completed descriptor produces a one-cycle `tx_done` pulse. The control/status block uses this pulse to set its transmit-interrupt and interrupt-summary flags.

Top module: `txr_scanner`

## Requirements
- R1: After reset, `mem_req`, `tx_valid`, `tx_last`, `tx_done` and `scan_busy` are low and `cur_idx` is 0.
- R2: A `poll` pulse has no effect while `tx_enable` is low: no memory access is made and `scan_busy` stays low.
- R3: A descriptor is serviced only when its status byte (offset 2) is exactly 0x83, meaning owner bit 0x80 plus start 0x02 plus end 0x01. Any other value, such as 0x82, 0x81, 0xC3 or 0x03, is passed over without streaming data and without changing the status byte.
- R4: The byte count is the two's-complement negation of a 16-bit field whose most significant byte is at offset 4 and least significant byte is at offset 5. For example, 0xFFF6 gives 10 bytes.
- R5: The bytes of a serviced descriptor appear on `tx_data` with `tx_valid`, in address order, starting at the slot's buffer base. `tx_last` is high only on the final byte.
- R6: After the final byte, the status byte is rewritten to 0x03, which clears ownership. `tx_done` then pulses for exactly one cycle.
- R7: `cur_idx` advances by one, modulo the ring size, for each serviced descriptor. Entries that are passed over do not advance it.
- R8: A scan starting at index `s` reads the status of slots `s`, `s+1`, … (wrapping) and stops without reading slot `(s-1) mod ring size`.
- R9: At most one memory access is outstanding: `mem_req` is not raised again until the previous request has been answered by `mem_ack`.
- R10: A length field of 0x0000 gives a zero byte count. No bytes are streamed, but the descriptor is still handed back and `tx_done` still pulses.
- R11: A `poll` that arrives while a scan is in progress is ignored. The running scan finishes unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_enable | input | 1 | Transmit path running (start and transmit-on active) |
| poll | input | 1 | Request to begin a ring scan |
| mem_req | output | 1 | One-cycle memory access request |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | AW | Byte address of the access |
| mem_wdata | output | 8 | Write data |
| mem_ack | input | 1 | Response for the outstanding access |
| mem_rdata | input | 8 | Read data, valid with `mem_ack` |
| tx_valid | output | 1 | Outgoing byte valid |
| tx_data | output | 8 | Outgoing packet byte |
| tx_last | output | 1 | Final byte of the packet |
| tx_done | output | 1 | One-cycle pulse per completed descriptor |
| scan_busy | output | 1 | A scan is in progress |
| cur_idx | output | RING_LOG | Current ring index |

## Verification
The bench fills the ring with three kinds of descriptor: owned complete ones, ones with nearly matching status bytes, and one with a zero length. This checks that only the exact 0x83 pattern is serviced and that the others stay untouched in memory. Consecutive scans start from different indices and mix serviced and skipped entries. This shows that the index moves once per serviced entry rather than once per visited entry, and that the slot just before the starting index is never read. The lengths chosen (1, 2, 3 and 10) have a high byte of 0xFF, so swapping the two length bytes would produce a very different count. A scoreboard compares every streamed byte and its end marker with the buffer contents the bench wrote.

// File: rtl/tx_ring_pkg.sv
package tx_ring_pkg;

  // status byte patterns
  localparam logic [7:0] STAT_READY    = 8'h83; // owned + start + end
  localparam logic [7:0] STAT_RETURNED = 8'h03; // start + end, owner cleared

  // byte offsets inside an 8-byte descriptor
  localparam logic [15:0] OFF_STAT = 16'd2;
  localparam logic [15:0] OFF_LENH = 16'd4;
  localparam logic [15:0] OFF_LENL = 16'd5;

  typedef enum logic [2:0] {
    S_IDLE,
    S_STAT,
    S_LENH,
    S_LENL,
    S_BUF,
    S_WSTAT
  } scan_state_t;

endpackage

// File: rtl/txr_len_decode.sv
module txr_len_decode (
  input  logic [7:0]  len_msb,
  input  logic [7:0]  len_lsb,
  output logic [15:0] byte_count
);
  logic [15:0] raw;

  always_comb begin
    raw        = {len_msb, len_lsb};
    byte_count = (~raw) + 16'd1;
  end
endmodule

// File: rtl/txr_addr_gen.sv
module txr_addr_gen #(
  parameter int AW = 16,
  parameter int IW = 2,
  parameter int BUF_LOG = 4,
  parameter logic [AW-1:0] DESC_BASE = '0,
  parameter logic [AW-1:0] BUF_BASE = '0
) (
  input  logic [IW-1:0] slot,
  input  logic          use_buf,
  input  logic [15:0]   offset,
  output logic [AW-1:0] addr
);
  localparam int DESC_SHIFT = 3;

  logic [AW-1:0] slot_w;
  logic [AW-1:0] off_w;

  always_comb begin
    slot_w = AW'(slot);
    off_w  = AW'(offset);
    if (use_buf)
      addr = BUF_BASE + (slot_w << BUF_LOG) + off_w;
    else
      addr = DESC_BASE + (slot_w << DESC_SHIFT) + off_w;
  end
endmodule

// File: rtl/txr_scanner.sv
module txr_scanner
  import tx_ring_pkg::*;
#(
  parameter int AW = 16,
  parameter int RING_LOG = 2,
  parameter int BUF_LOG = 4,
  parameter logic [AW-1:0] DESC_BASE = 16'h0000,
  parameter logic [AW-1:0] BUF_BASE = 16'h0040
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                tx_enable,
  input  logic                poll,
  output logic                mem_req,
  output logic                mem_we,
  output logic [AW-1:0]       mem_addr,
  output logic [7:0]          mem_wdata,
  input  logic                mem_ack,
  input  logic [7:0]          mem_rdata,
  output logic                tx_valid,
  output logic [7:0]          tx_data,
  output logic                tx_last,
  output logic                tx_done,
  output logic                scan_busy,
  output logic [RING_LOG-1:0] cur_idx
);
  localparam int IW = RING_LOG;

  scan_state_t   state;
  logic          wait_q;
  logic [IW-1:0] slot;
  logic [IW-1:0] stop_slot;
  logic [7:0]    len_msb_q;
  logic [15:0]   byte_total;
  logic [15:0]   byte_num;

  logic [15:0]   dec_count;
  logic [AW-1:0] acc_addr;
  logic          acc_buf;
  logic [15:0]   acc_off;
  logic [IW-1:0] slot_nxt;
  logic          scan_end;
  logic          final_byte;

  txr_len_decode u_len (
    .len_msb   (len_msb_q),
    .len_lsb   (mem_rdata),
    .byte_count(dec_count)
  );

  txr_addr_gen #(
    .AW(AW), .IW(IW), .BUF_LOG(BUF_LOG),
    .DESC_BASE(DESC_BASE), .BUF_BASE(BUF_BASE)
  ) u_addr (
    .slot   (slot),
    .use_buf(acc_buf),
    .offset (acc_off),
    .addr   (acc_addr)
  );

  always_comb begin
    acc_buf = 1'b0;
    acc_off = OFF_STAT;
    case (state)
      S_LENH:  acc_off = OFF_LENH;
      S_LENL:  acc_off = OFF_LENL;
      S_BUF: begin
        acc_buf = 1'b1;
        acc_off = byte_num;
      end
      default: acc_off = OFF_STAT;
    endcase
    slot_nxt   = slot + 1'b1;
    scan_end   = (slot_nxt == stop_slot);
    final_byte = (byte_num == byte_total - 16'd1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= S_IDLE;
      wait_q     <= 1'b0;
      slot       <= '0;
      stop_slot  <= '0;
      len_msb_q  <= '0;
      byte_total <= '0;
      byte_num   <= '0;
      cur_idx    <= '0;
      scan_busy  <= 1'b0;
      mem_req    <= 1'b0;
      mem_we     <= 1'b0;
      mem_addr   <= '0;
      mem_wdata  <= '0;
      tx_valid   <= 1'b0;
      tx_data    <= '0;
      tx_last    <= 1'b0;
      tx_done    <= 1'b0;
    end else begin
      mem_req  <= 1'b0;
      tx_valid <= 1'b0;
      tx_last  <= 1'b0;
      tx_done  <= 1'b0;
      if (state == S_IDLE) begin
        if (poll && tx_enable) begin
          slot      <= cur_idx;
          stop_slot <= cur_idx - 1'b1;
          scan_busy <= 1'b1;
          state     <= S_STAT;
        end
      end else if (!wait_q) begin
        mem_req   <= 1'b1;
        mem_we    <= (state == S_WSTAT);
        mem_wdata <= STAT_RETURNED;
        mem_addr  <= acc_addr;
        wait_q    <= 1'b1;
      end else if (mem_ack) begin
        wait_q <= 1'b0;
        case (state)
          S_STAT: begin
            if (mem_rdata == STAT_READY) begin
              state <= S_LENH;
            end else if (scan_end) begin
              state     <= S_IDLE;
              scan_busy <= 1'b0;
            end else begin
              slot  <= slot_nxt;
              state <= S_STAT;
            end
          end
          S_LENH: begin
            len_msb_q <= mem_rdata;
            state     <= S_LENL;
          end
          S_LENL: begin
            byte_total <= dec_count;
            byte_num   <= '0;
            state      <= (dec_count == 16'd0) ? S_WSTAT : S_BUF;
          end
          S_BUF: begin
            tx_valid <= 1'b1;
            tx_data  <= mem_rdata;
            tx_last  <= final_byte;
            byte_num <= byte_num + 16'd1;
            if (final_byte) state <= S_WSTAT;
          end
          S_WSTAT: begin
            tx_done <= 1'b1;
            cur_idx <= cur_idx + 1'b1;
            if (scan_end) begin
              state     <= S_IDLE;
              scan_busy <= 1'b0;
            end else begin
              slot  <= slot_nxt;
              state <= S_STAT;
            end
          end
          default: state <= S_IDLE;
        endcase
      end
    end
  end

  // outstanding-access tracker used only by the checks below
  logic chk_pending;
  always_ff @(posedge clk) begin
    if (rst) chk_pending <= 1'b0;
    else if (mem_req) chk_pending <= 1'b1;
    else if (mem_ack) chk_pending <= 1'b0;
  end

  // R9
  single_access_chk: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> !chk_pending);

  // R2
  req_only_in_scan_chk: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> scan_busy);

  // R5
  byte_from_response_chk: assert property (@(posedge clk) disable iff (rst)
    tx_valid |-> $past(mem_ack));

  // R5
  last_with_valid_chk: assert property (@(posedge clk) disable iff (rst)
    tx_last |-> tx_valid);

  // R6
  done_after_write_chk: assert property (@(posedge clk) disable iff (rst)
    tx_done |-> $past(mem_ack && mem_we));

  // R7
  idx_step_chk: assert property (@(posedge clk) disable iff (rst)
    tx_done |-> cur_idx == IW'($past(cur_idx) + 1'b1));

endmodule

// File: tb/txr_scanner_tb.sv
module txr_scanner_tb;
  localparam int AW = 16;
  localparam int RING_LOG = 2;
  localparam int BUF_LOG = 4;
  localparam int BUFB = 64;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tx_enable = 1'b0;
  logic poll = 1'b0;
  logic mem_req, mem_we;
  logic [AW-1:0] mem_addr;
  logic [7:0] mem_wdata;
  logic mem_ack = 1'b0;
  logic [7:0] mem_rdata = '0;
  logic tx_valid, tx_last, tx_done, scan_busy;
  logic [7:0] tx_data;
  logic [RING_LOG-1:0] cur_idx;

  always #5 clk = ~clk;

  txr_scanner #(.AW(AW), .RING_LOG(RING_LOG), .BUF_LOG(BUF_LOG),
                .DESC_BASE(16'h0000), .BUF_BASE(16'h0040)) u_dut (
    .clk(clk), .rst(rst), .tx_enable(tx_enable), .poll(poll),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .tx_valid(tx_valid), .tx_data(tx_data), .tx_last(tx_last),
    .tx_done(tx_done), .scan_busy(scan_busy), .cur_idx(cur_idx)
  );

  int checks = 0;
  int fails = 0;

  // memory model, sole writer of mem
  logic [7:0] mem [0:255];
  logic poke_en = 1'b0;
  logic [7:0] poke_addr = '0;
  logic [7:0] poke_data = '0;
  logic clr_rd = 1'b0;
  logic [3:0] stat_read;
  logic outstanding;
  int req_count = 0;
  int proto_err = 0;

  always @(posedge clk) begin
    mem_ack <= 1'b0;
    if (rst) begin
      for (int i = 0; i < 256; i++) mem[i] <= 8'h00;
      stat_read   <= '0;
      outstanding <= 1'b0;
    end else begin
      if (poke_en) mem[poke_addr] <= poke_data;
      if (clr_rd) stat_read <= '0;
      if (mem_req) begin
        req_count <= req_count + 1;
        if (outstanding) proto_err <= proto_err + 1;
        outstanding <= 1'b1;
        mem_ack <= 1'b1;
        if (mem_we) mem[mem_addr[7:0]] <= mem_wdata;
        else mem_rdata <= mem[mem_addr[7:0]];
        if (!mem_we && mem_addr < 16'd32 && mem_addr[2:0] == 3'd2)
          stat_read[mem_addr[4:3]] <= 1'b1;
      end else if (mem_ack) begin
        outstanding <= 1'b0;
      end
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // scoreboard
  logic [8:0] exp_q[$];
  int done_cnt = 0;
  int byte_cnt = 0;

  always @(negedge clk) begin
    if (!rst) begin
      if (tx_done) done_cnt++;
      if (tx_valid) begin
        byte_cnt++;
        if (exp_q.size() == 0) begin
          checks++; fails++;
          $display("FAIL R5 actual=%0h expected=none", {tx_last, tx_data});
        end else begin
          check("R5 byte/last", {23'd0, tx_last, tx_data}, {23'd0, exp_q.pop_front()});
        end
      end
    end
  end

  function automatic logic [7:0] pattern(input int slot, input int k);
    return 8'(slot * 16 + k * 3 + 5);
  endfunction

  task automatic poke(input int a, input logic [7:0] d);
    @(negedge clk);
    poke_addr = 8'(a); poke_data = d; poke_en = 1'b1;
    @(negedge clk);
    poke_en = 1'b0;
  endtask

  task automatic set_desc(input int slot, input logic [7:0] st, input logic [15:0] lenf);
    poke(slot * 8 + 2, st);
    poke(slot * 8 + 4, lenf[15:8]);
    poke(slot * 8 + 5, lenf[7:0]);
  endtask

  task automatic push_pkt(input int slot, input int n);
    for (int k = 0; k < n; k++) exp_q.push_back({(k == n - 1), pattern(slot, k)});
  endtask

  task automatic clear_reads();
    @(negedge clk); clr_rd = 1'b1;
    @(negedge clk); clr_rd = 1'b0;
  endtask

  task automatic run_scan(input bit repoll);
    @(negedge clk); poll = 1'b1;
    @(negedge clk); poll = 1'b0;
    if (repoll) begin
      repeat (6) @(negedge clk);
      poll = 1'b1;
      @(negedge clk); poll = 1'b0;
    end
    for (int t = 0; t < 3000 && scan_busy; t++) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int d0, b0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1
    check("R1 mem_req", mem_req, 0);
    check("R1 tx_valid", {tx_valid, tx_last}, 0);
    check("R1 tx_done", tx_done, 0);
    check("R1 scan_busy", scan_busy, 0);
    check("R1 cur_idx", cur_idx, 0);

    // R2: poll while disabled
    run_scan(1'b0);
    check("R2 no access", req_count, 0);
    check("R2 not busy", scan_busy, 0);

    for (int s = 0; s < 4; s++)
      for (int k = 0; k < 16; k++) poke(BUFB + s * 16 + k, pattern(s, k));

    // scan A from index 0: slot 3 must not be read
    set_desc(0, 8'h83, 16'hFFFD);
    set_desc(1, 8'h82, 16'hFFFE);
    set_desc(2, 8'h83, 16'hFFFE);
    set_desc(3, 8'h83, 16'hFFFF);
    push_pkt(0, 3);
    push_pkt(2, 2);
    clear_reads();
    tx_enable = 1'b1;
    d0 = done_cnt; b0 = byte_cnt;
    run_scan(1'b1); // R11: second poll during the scan
    check("R6 done pulses A", done_cnt - d0, 2);
    check("R4 bytes A", byte_cnt - b0, 5);
    check("R7 idx after A", cur_idx, 2);
    check("R6 stat0 returned", mem[2], 8'h03);
    check("R6 stat2 returned", mem[18], 8'h03);
    check("R3 stat1 untouched", mem[10], 8'h82);
    check("R8 slot3 not read", stat_read[3], 0);
    check("R8 slots0-2 read", stat_read[2:0], 3'b111);
    check("R8 stat3 kept", mem[26], 8'h83);
    check("R11 scoreboard empty A", exp_q.size(), 0);

    // scan B from index 2, zero-length descriptor in slot 0
    set_desc(0, 8'h83, 16'h0000);
    push_pkt(3, 1);
    clear_reads();
    d0 = done_cnt; b0 = byte_cnt;
    run_scan(1'b0);
    check("R10 done pulses B", done_cnt - d0, 2);
    check("R10 bytes B", byte_cnt - b0, 1);
    check("R10 stat0 returned", mem[2], 8'h03);
    check("R7 idx after B", cur_idx, 0);
    check("R8 slot1 not read", stat_read[1], 0);
    check("R5 scoreboard empty B", exp_q.size(), 0);

    // scan C from index 0: near-miss status values, 10-byte packet
    set_desc(0, 8'hC3, 16'hFFFC);
    set_desc(1, 8'h81, 16'hFFFC);
    set_desc(2, 8'h83, 16'hFFF6);
    set_desc(3, 8'h03, 16'hFFFC);
    push_pkt(2, 10);
    d0 = done_cnt; b0 = byte_cnt;
    run_scan(1'b0);
    check("R3 done pulses C", done_cnt - d0, 1);
    check("R4 bytes C", byte_cnt - b0, 10);
    check("R3 stat0 0xC3 kept", mem[2], 8'hC3);
    check("R3 stat1 0x81 kept", mem[10], 8'h81);
    check("R7 idx after C", cur_idx, 1);
    check("R5 scoreboard empty C", exp_q.size(), 0);

    // R2 again: disabled after activity
    tx_enable = 1'b0;
    b0 = req_count;
    run_scan(1'b0);
    check("R2 no access when disabled", req_count - b0, 0);
    check("R9 one outstanding", proto_err, 0);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule